// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver with Three-Sample Vote

This block turns an asynchronous serial line into parallel bytes. An external rate generator supplies a one-clock `sample_en` pulse at sixteen times the bit rate. The line first passes through a two-flop synchronizer. The receiver then sits idle until a sampled low level marks a candidate start bit, and it uses that edge to set the phase of its bit timing.

Every bit period spans sixteen samples. The bit value is the 2-of-3 majority of the 7th, 8th and 9th samples. A single noisy sample inside that window is therefore outvoted, and samples outside the window have no effect. The frame holds a start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit.

When the stop bit has been decided, the byte is loaded into a single holding register and a done flag is raised. That flag stays set until the host clears it. Framing, parity and overrun flags go out with each frame.

Top module: `uart_rx_vote`

## Requirements
- R1: `rxd` reaches the sampling logic through two clocked flops. While idle, the receiver changes no output and only leaves idle on a `sample_en` cycle that sees the synchronized line low. That sample counts as sample index 0 of the start bit.
- R2: If the start bit's vote reads high, the receiver returns to idle. No output changes: `rx_done` and `rx_data` keep their values.
- R3: Sample indices within a bit run 0 to 15. The bit value is the majority of indices 6, 7 and 8. A single differing sample among the three does not change the bit. Samples at other indices have no effect. Two differing samples in the window flip the bit.
- R4: The frame is: start bit (0), eight data bits with the first received bit going to `rx_data[0]`, a parity bit only when `par_en`=1, then the stop bit. In the clock after the `sample_en` cycle at index 8 of the stop bit, `rx_data` holds the byte and `rx_done` is 1. `rx_data` changes at no other time.
- R5: With `par_en`=1, the expected parity bit is the XOR of the eight data bits, inverted when `par_odd`=1 (`par_odd`=0 selects even parity). `err_parity` is set to 1 on mismatch and to 0 on match, at each frame completion. With `par_en`=0, `err_parity` is 0 after each frame.
- R6: A stop bit that votes low sets `err_frame` to 1 at completion, and the byte is still delivered. A stop bit that votes high sets `err_frame` to 0.
- R7: `rx_done` stays 1 until a `clr_done` pulse clears it. When a frame completes in the same cycle as `clr_done`, `rx_done` is 1 afterwards.
- R8: A frame that completes while `rx_done` is 1 and `clr_done` is 0 sets `err_overrun` to 1 and still loads the new byte. `err_overrun` holds until a `clr_done` pulse clears it.
- R9: After reset, `rx_data` is 0 and `rx_done`, `err_frame`, `err_parity` and `err_overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | One-clock pulse at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| par_en | input | 1 | 1 = frame carries a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| clr_done | input | 1 | Host pulse clearing rx_done and err_overrun |
| rx_data | output | 8 | Last received byte |
| rx_done | output | 1 | A byte is waiting for the host |
| err_frame | output | 1 | Last frame's stop bit read low |
| err_parity | output | 1 | Last frame's parity bit mismatched |
| err_overrun | output | 1 | A byte arrived while rx_done was still set |

## Verification
The bench builds the receiver with its default sixteen samples per bit and an eight-bit byte. It spaces `sample_en` four clocks apart, so the two-flop synchronizer settles between samples and each driven sample lands on a known index. This makes it possible to place a noisy sample exactly inside or outside the 7th to 9th window of a chosen bit. It also lets the bench place a start pulse that is too short, and a low stop bit that forces a restart, so the glitch, vote, framing and overrun paths are all exercised with exact timing.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= pipe_d;
  end

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_rx_voter.sv
module uart_rx_voter #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic arm,
  input  logic active,
  input  logic line,
  output logic vote_valid,
  output logic vote_bit
);
  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] IDX_C    = CNT_W'(OSR / 2);
  localparam logic [CNT_W-1:0] IDX_A    = CNT_W'(OSR / 2 - 2);
  localparam logic [CNT_W-1:0] IDX_B    = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] IDX_LAST = CNT_W'(OSR - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             smp_a_q, smp_a_d;
  logic             smp_b_q, smp_b_d;
  logic             tick;

  assign tick = active & sample_en;

  always_comb begin
    cnt_d   = cnt_q;
    smp_a_d = smp_a_q;
    smp_b_d = smp_b_q;
    if (arm) begin
      cnt_d = CNT_W'(1);
    end else if (tick) begin
      cnt_d = (cnt_q == IDX_LAST) ? '0 : cnt_q + CNT_W'(1);
      if (cnt_q == IDX_A) smp_a_d = line;
      if (cnt_q == IDX_B) smp_b_d = line;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      smp_a_q <= 1'b1;
      smp_b_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      smp_a_q <= smp_a_d;
      smp_b_q <= smp_b_d;
    end
  end

  assign vote_valid = tick & (cnt_q == IDX_C);
  assign vote_bit   = (smp_a_q & smp_b_q) | (smp_a_q & line) | (smp_b_q & line);

  // R3: a vote only ever follows a captured pair of window samples one tick apart
  assert_vote_after_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == IDX_B) |=> (cnt_q == IDX_C));
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic              line,
  input  logic              vote_valid,
  input  logic              vote_bit,
  input  logic              par_en,
  output logic              arm,
  output logic              active,
  output logic              frame_done,
  output logic              stop_bit,
  output logic [DATA_W-1:0] shift_q,
  output logic              par_used,
  output logic              par_bit
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  rx_state_t         state_q, state_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] shift_d;
  logic              par_used_d, par_bit_d;

  assign arm        = (state_q == ST_IDLE) & sample_en & ~line;
  assign active     = (state_q != ST_IDLE);
  assign frame_done = (state_q == ST_STOP) & vote_valid;
  assign stop_bit   = vote_bit;

  always_comb begin
    state_d    = state_q;
    bit_d      = bit_q;
    shift_d    = shift_q;
    par_used_d = par_used;
    par_bit_d  = par_bit;
    case (state_q)
      ST_IDLE: begin
        if (arm) state_d = ST_START;
      end
      ST_START: begin
        if (vote_valid) begin
          bit_d   = '0;
          state_d = vote_bit ? ST_IDLE : ST_DATA;
        end
      end
      ST_DATA: begin
        if (vote_valid) begin
          shift_d = {vote_bit, shift_q[DATA_W-1:1]};
          bit_d   = bit_q + BIT_W'(1);
          if (bit_q == BIT_LAST) begin
            par_used_d = par_en;
            state_d    = par_en ? ST_PAR : ST_STOP;
          end
        end
      end
      ST_PAR: begin
        if (vote_valid) begin
          par_bit_d = vote_bit;
          state_d   = ST_STOP;
        end
      end
      ST_STOP: begin
        if (vote_valid) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bit_q    <= '0;
      shift_q  <= '0;
      par_used <= 1'b0;
      par_bit  <= 1'b0;
    end else begin
      state_q  <= state_d;
      bit_q    <= bit_d;
      shift_q  <= shift_d;
      par_used <= par_used_d;
      par_bit  <= par_bit_d;
    end
  end

  assert_glitch_to_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && vote_valid && vote_bit) |=> (state_q == ST_IDLE));

  assert_idle_waits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !(sample_en && !line)) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote #(
  parameter int OSR         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              clr_done,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_done,
  output logic              err_frame,
  output logic              err_parity,
  output logic              err_overrun
);
  logic              line;
  logic              arm, active, vote_valid, vote_bit;
  logic              frame_done, stop_bit, par_used, par_bit;
  logic [DATA_W-1:0] shift_q;
  logic              par_bad;

  logic [DATA_W-1:0] data_d;
  logic              done_d, ferr_d, perr_d, ovr_d;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_n), .din (rxd), .dout (line)
  );

  uart_rx_voter #(.OSR(OSR)) u_voter (
    .clk (clk), .rst_n (rst_n), .sample_en (sample_en), .arm (arm),
    .active (active), .line (line), .vote_valid (vote_valid), .vote_bit (vote_bit)
  );

  uart_rx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk (clk), .rst_n (rst_n), .sample_en (sample_en), .line (line),
    .vote_valid (vote_valid), .vote_bit (vote_bit), .par_en (par_en),
    .arm (arm), .active (active), .frame_done (frame_done), .stop_bit (stop_bit),
    .shift_q (shift_q), .par_used (par_used), .par_bit (par_bit)
  );

  assign par_bad = par_used & ((^shift_q) ^ par_odd ^ par_bit);

  always_comb begin
    data_d = rx_data;
    done_d = rx_done;
    ferr_d = err_frame;
    perr_d = err_parity;
    ovr_d  = err_overrun;
    if (clr_done) begin
      done_d = 1'b0;
      ovr_d  = 1'b0;
    end
    if (frame_done) begin
      data_d = shift_q;
      done_d = 1'b1;
      ferr_d = ~stop_bit;
      perr_d = par_bad;
      if (rx_done && !clr_done) ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_done     <= 1'b0;
      err_frame   <= 1'b0;
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      rx_data     <= data_d;
      rx_done     <= done_d;
      err_frame   <= ferr_d;
      err_parity  <= perr_d;
      err_overrun <= ovr_d;
    end
  end

  assert_data_only_on_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(rx_data));

  assert_no_perr_unused_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !par_used) |=> !err_parity);

  assert_low_stop_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !stop_bit) |=> err_frame);

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !clr_done) |=> rx_done);

  assert_overrun_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_done && !clr_done) |=> err_overrun);
endmodule

// File: tb/uart_rx_vote_tb.sv
module uart_rx_vote_tb;
  logic       clk, rst_n, sample_en, rxd, par_en, par_odd, clr_done;
  logic [7:0] rx_data;
  logic       rx_done, err_frame, err_parity, err_overrun;
  int n_checks, n_fail, div_cnt;

  uart_rx_vote u_dut (
    .clk (clk), .rst_n (rst_n), .sample_en (sample_en), .rxd (rxd),
    .par_en (par_en), .par_odd (par_odd), .clr_done (clr_done),
    .rx_data (rx_data), .rx_done (rx_done), .err_frame (err_frame),
    .err_parity (err_parity), .err_overrun (err_overrun)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // sample_en: one pulse every four clocks
  always @(negedge clk) begin
    div_cnt   <= (div_cnt == 3) ? 0 : div_cnt + 1;
    sample_en <= (div_cnt == 3);
  end

  // ---------------- behavioural reference model ----------------
  int   m_s1, m_s2, m_phase, m_pos, m_nbit, m_pv, m_vote, m_ones;
  int   m_smp [16];
  int   m_bits [8];
  int   m_data, m_done, m_ferr, m_perr, m_ovr, m_pused;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_phase = 0; m_pos = 0; m_nbit = 0;
      m_data = 0; m_done = 0; m_ferr = 0; m_perr = 0; m_ovr = 0; m_pused = 0; m_pv = 0;
    end else begin
      int rs, fin, fin_stop;
      rs = m_s2; fin = 0; fin_stop = 0;
      m_s2 = m_s1; m_s1 = rxd;
      if (sample_en) begin
        if (m_phase == 0) begin
          if (rs == 0) begin m_phase = 1; m_smp[0] = 0; m_pos = 1; end
        end else begin
          m_smp[m_pos] = rs;
          if (m_pos == 8) begin
            m_vote = ((m_smp[6] + m_smp[7] + m_smp[8]) >= 2) ? 1 : 0;
            case (m_phase)
              1: if (m_vote == 1) m_phase = 0; else begin m_phase = 2; m_nbit = 0; end
              2: begin
                m_bits[m_nbit] = m_vote; m_nbit++;
                if (m_nbit == 8) begin m_pused = par_en; m_phase = par_en ? 3 : 4; end
              end
              3: begin m_pv = m_vote; m_phase = 4; end
              default: begin fin = 1; fin_stop = m_vote; m_phase = 0; end
            endcase
          end
          m_pos = (m_pos + 1) % 16;
        end
      end
      if (clr_done) m_ovr = 0;
      if (fin) begin
        if (m_done == 1 && !clr_done) m_ovr = 1;
        m_data = 0; m_ones = 0;
        for (int i = 0; i < 8; i++) begin m_data += m_bits[i] << i; m_ones += m_bits[i]; end
        m_ferr = fin_stop ? 0 : 1;
        m_perr = (m_pused != 0) ? (((m_ones + m_pv + par_odd) % 2) != 0) : 0;
        m_done = 1;
      end else if (clr_done) m_done = 0;
    end
  end

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      n_checks++;
      if (rx_data !== 8'(m_data) || rx_done !== 1'(m_done) || err_frame !== 1'(m_ferr) ||
          err_parity !== 1'(m_perr) || err_overrun !== 1'(m_ovr)) begin
        n_fail++;
        $display("FAIL R1 per-clock model: actual=%h/%b%b%b%b expected=%h/%b%b%b%b",
                 rx_data, rx_done, err_frame, err_parity, err_overrun,
                 8'(m_data), 1'(m_done), 1'(m_ferr), 1'(m_perr), 1'(m_ovr));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold1(input logic v);
    rxd = v;
    @(posedge clk iff sample_en);
    @(negedge clk);
  endtask

  task automatic send_bit(input logic v, input logic [15:0] mask);
    for (int i = 0; i < 16; i++) hold1(v ^ mask[i]);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic pe, input logic pb,
                            input logic sb, input int fbit, input logic [15:0] fmask);
    hold1(1'b1);
    send_bit(1'b0, 16'h0);
    for (int i = 0; i < 8; i++) send_bit(d[i], (i == fbit) ? fmask : 16'h0);
    if (pe) send_bit(pb, 16'h0);
    send_bit(sb, 16'h0);
    for (int i = 0; i < 4; i++) hold1(1'b1);
  endtask

  task automatic clear_done();
    clr_done = 1'b1;
    @(negedge clk);
    clr_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    n_checks = 0; n_fail = 0; div_cnt = 0;
    sample_en = 1'b0; rxd = 1'b1; par_en = 1'b0; par_odd = 1'b0; clr_done = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 rx_data", rx_data, 8'h00);
    chk("R9 flags", {4'h0, rx_done, err_frame, err_parity, err_overrun}, 8'h00);

    // R1 idle line high: nothing happens
    for (int i = 0; i < 40; i++) hold1(1'b1);
    chk("R1 idle rx_done", {7'h0, rx_done}, 8'h00);

    // R4 plain frame, no parity
    send_frame(8'hA5, 1'b0, 1'b0, 1'b1, -1, 16'h0);
    chk("R4 data A5", rx_data, 8'hA5);
    chk("R4 done", {7'h0, rx_done}, 8'h01);
    chk("R5 no parity perr", {7'h0, err_parity}, 8'h00);
    repeat (40) @(negedge clk);
    chk("R7 done held", {7'h0, rx_done}, 8'h01);
    clear_done();
    chk("R7 cleared", {7'h0, rx_done}, 8'h00);

    // R4 LSB first
    send_frame(8'h01, 1'b0, 1'b0, 1'b1, -1, 16'h0);
    chk("R4 lsb first", rx_data, 8'h01);
    clear_done();

    // R5 even parity, correct bit 0 for 0x3C
    par_en = 1'b1; par_odd = 1'b0;
    send_frame(8'h3C, 1'b1, 1'b0, 1'b1, -1, 16'h0);
    chk("R5 even ok", {7'h0, err_parity}, 8'h00);
    chk("R5 even data", rx_data, 8'h3C);
    clear_done();
    // R5 odd parity, correct bit 1
    par_odd = 1'b1;
    send_frame(8'h3C, 1'b1, 1'b1, 1'b1, -1, 16'h0);
    chk("R5 odd ok", {7'h0, err_parity}, 8'h00);
    clear_done();
    // R5 odd parity, wrong bit 0
    send_frame(8'h3C, 1'b1, 1'b0, 1'b1, -1, 16'h0);
    chk("R5 odd mismatch", {7'h0, err_parity}, 8'h01);
    clear_done();
    par_en = 1'b0; par_odd = 1'b0;

    // R6 stop bit low
    send_frame(8'h81, 1'b0, 1'b0, 1'b0, -1, 16'h0);
    chk("R6 framing flag", {7'h0, err_frame}, 8'h01);
    chk("R6 data kept", rx_data, 8'h81);
    clear_done();
    chk("R6 restart no frame", {7'h0, rx_done}, 8'h00);

    // R2 short low pulse: start vote high
    hold1(1'b1);
    for (int i = 0; i < 5; i++) hold1(1'b0);
    for (int i = 0; i < 30; i++) hold1(1'b1);
    chk("R2 glitch done", {7'h0, rx_done}, 8'h00);
    chk("R2 glitch data", rx_data, 8'h81);

    // R3 one outlier in window plus all outside samples flipped: bit stays 0
    send_frame(8'h00, 1'b0, 1'b0, 1'b1, 0, 16'hFEBF);
    chk("R3 single outlier", rx_data, 8'h00);
    clear_done();
    // R3 two of three flipped in bit 3: bit reads 1
    send_frame(8'h00, 1'b0, 1'b0, 1'b1, 3, 16'h0180);
    chk("R3 two flipped", rx_data, 8'h08);
    chk("R6 good stop", {7'h0, err_frame}, 8'h00);

    // R8 overrun: new frame while done still set
    send_frame(8'h5A, 1'b0, 1'b0, 1'b1, -1, 16'h0);
    chk("R8 overrun flag", {7'h0, err_overrun}, 8'h01);
    chk("R8 new data", rx_data, 8'h5A);
    clear_done();
    chk("R8 overrun cleared", {7'h0, err_overrun}, 8'h00);
    chk("R7 done cleared", {7'h0, rx_done}, 8'h00);

    finish_run();
  end
endmodule